// File: doc/BRIEF.md
# Bootstrap Strap Capture and Configuration Decoder

This block takes a bundle of bootstrap inputs that select a device's start-up configuration. It latches them once after a hard reset is released, keeps that snapshot for the rest of the session, and decodes it into the working settings: a station address, the I/O supply level, the supply arrangement, the MAC interface type, port mirroring, a lock on management writes, and the link mode (auto-negotiation with an advertised speed set, or one of several forced modes). The address comes from two four-level inputs. The analog front end has already turned each of them into a 2-bit level code, so the block treats them as binary.

The management side can overwrite any decoded setting field by field, unless the write lock strap is set. Each override lasts until the next reset of any kind. A synchronous software reset drops the overrides, and the outputs go back to the held snapshot without resampling the pins. A single-cycle fault event always raises a one-cycle interrupt pulse. When the recovery strap is set, the event also starts a fixed-width internal logic reset, and that reset clears the overrides. If a reserved code is selected, the setting falls back to its default meaning and a sticky flag is set.

Top module: `strap_cfg_top`

## Requirements
- R1: The strap inputs are captured on the third rising clock edge after `por_rst_n` goes high: two edges synchronise the reset release and the third loads the pins. After that capture, changes on the strap pins have no effect on any output until the next assertion of `por_rst_n`.
- R2: A one-cycle `sw_rst` pulse does not resample the pins. From the next cycle on, every output again shows the decode of the snapshot taken at the last hard reset.
- R3: `phy_addr` equals `strap_addr_lvl`. Level pin 0 (`strap_addr_lvl[1:0]`) supplies address bits [1:0], and level pin 1 (`strap_addr_lvl[3:2]`) supplies bits [3:2]. Level codes 0 to 3 map to binary 00 to 11.
- R4: `io_volt` decodes from `strap_vio` = {sel1,sel0}:
  - 00 gives 0 (3.3 V).
  - 10 gives 1 (2.5 V).
  - 11 gives 2 (1.8 V).
  - 01 is reserved and gives 0.
- R5: When the auto-negotiation-disable input is 0, `link_mode` follows `strap_lsel`:
  - 00 gives 0 (advertise 1000/100/10).
  - 01 gives 1 (advertise 1000/100).
  - 10 gives 2 (advertise 100/10).
  - 11 is reserved and gives 0.
  All of these modes use automatic crossover.
- R6: When the auto-negotiation-disable input is 1, `link_mode` follows `strap_lsel`:
  - 00 gives 3 (forced 1000M master).
  - 01 gives 4 (forced 1000M slave).
  - 10 gives 5 (forced 100M full duplex, straight).
  - 11 gives 6 (forced 100M full duplex, crossover).
- R7: `triple_supply`, `mii_mode` and `mirror_en` each follow their strap bit. While `por_rst_n` is low, every output shows the decode of all-zero straps: address 0, `io_volt` 0, `link_mode` 0, and all flags 0.
- R8: While the write-lock strap is 1, `wr_blocked` is 1 and management writes change no setting.
- R9: A management write takes effect from the cycle after its clock edge. The field is chosen by `wr_sel`:
  - 0: address, taken from `wr_val[3:0]`.
  - 1: voltage code, `wr_val[1:0]`.
  - 2: supply, `wr_val[0]`.
  - 3: interface, `wr_val[0]`.
  - 4: mirroring, `wr_val[0]`.
  - 5: link, where `wr_val[2]` is the auto-negotiation disable and `wr_val[1:0]` is the select.
  An override is cleared by `sw_rst`, by `logic_rst` and by a hard reset.
- R10: A reserved voltage or link code, whether it comes from the straps or from a write, sets `rsv_seen` one cycle after that code becomes active. Only a hard reset clears `rsv_seen`.
- R11: `fault_irq` is high for exactly the cycle after each clock edge on which `fault_evt` is sampled high. This holds whatever the recovery strap is set to.
- R12: When the recovery strap is 1, a `fault_evt` pulse drives `logic_rst` high for exactly 4 cycles, starting the cycle after the event. A fault event that arrives during the pulse does not extend or restart it. A write made during the pulse is ignored, and the pulse clears every override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Asynchronous active-low hard reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| strap_addr_lvl | input | 4 | Two quantised 4-level address straps |
| strap_vio | input | 2 | I/O voltage select {sel1,sel0} |
| strap_supply | input | 1 | Supply arrangement strap |
| strap_mii | input | 1 | MAC interface strap (1 = MII) |
| strap_recover | input | 1 | Fault auto-recovery enable strap |
| strap_mirror | input | 1 | Port mirroring strap |
| strap_wr_dis | input | 1 | Management write lock strap |
| strap_an_dis | input | 1 | Auto-negotiation disable strap |
| strap_lsel | input | 2 | Link mode select {sel1,sel0} |
| fault_evt | input | 1 | Functional-interrupt fault event |
| wr_en | input | 1 | Management write strobe |
| wr_sel | input | 3 | Field selected for the write |
| wr_val | input | 4 | Write data |
| phy_addr | output | 4 | Station address |
| io_volt | output | 2 | I/O voltage level code |
| triple_supply | output | 1 | Triple supply mode |
| mii_mode | output | 1 | MII selected (0 = RGMII) |
| mirror_en | output | 1 | Port mirroring enabled |
| wr_blocked | output | 1 | Management writes locked |
| link_mode | output | 3 | Decoded link mode |
| rsv_seen | output | 1 | Sticky reserved-code flag |
| fault_irq | output | 1 | Fault interrupt pulse |
| logic_rst | output | 1 | Auto-recovery logic reset pulse |

## Verification
The decoded settings are combinational from the held snapshot and the override registers. They are therefore due in the cycle right after the edge that loads the snapshot or accepts the write. The reserved flag and the interrupt are due one edge after their cause, and the recovery pulse occupies the four cycles that follow the event edge.

The bench drives inputs on falling edges and samples on falling edges. For each result it waits the exact number of rising edges that the result needs: four after the hard reset is released, one after a write or software reset, and a further edge for `rsv_seen`. It scrambles the strap pins before sampling, to show that they are no longer read. It counts the high cycles of `logic_rst` across a window that includes a second event.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

  localparam int ADDR_PINS = 2;
  localparam int ADDR_W    = 2 * ADDR_PINS;
  localparam int WR_W      = (ADDR_W > 3) ? ADDR_W : 3;
  localparam int NUM_FLD   = 6;

  typedef enum logic [1:0] {
    VIO_3V3 = 2'd0,
    VIO_2V5 = 2'd1,
    VIO_1V8 = 2'd2
  } vio_e;

  typedef enum logic [2:0] {
    LM_AN_ALL   = 3'd0,
    LM_AN_GIG   = 3'd1,
    LM_AN_FAST  = 3'd2,
    LM_F1000_M  = 3'd3,
    LM_F1000_S  = 3'd4,
    LM_F100_STR = 3'd5,
    LM_F100_X   = 3'd6
  } link_e;

  typedef enum logic [2:0] {
    FLD_ADDR   = 3'd0,
    FLD_VIO    = 3'd1,
    FLD_SUPPLY = 3'd2,
    FLD_MII    = 3'd3,
    FLD_MIRROR = 3'd4,
    FLD_LINK   = 3'd5
  } fld_e;

  // settings that management writes may override
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [1:0]        vio;
    logic              supply;
    logic              mii;
    logic              mirror;
    logic              an_dis;
    logic [1:0]        lsel;
  } raw_t;

  // full strap snapshot
  typedef struct packed {
    raw_t cfg;
    logic wr_dis;
    logic recover;
  } strap_t;

endpackage

// File: rtl/strap_rst_sync.sv
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] q_q, q_d;

  always_comb begin
    q_d = {q_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_q <= '0;
    else         q_q <= q_d;
  end

  assign rst_n_o = q_q[STAGES-1];

endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import strap_cfg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  strap_t pins,
  output strap_t held
);

  logic   pend_q, pend_d;
  strap_t held_q, held_d;

  always_comb begin
    pend_d = pend_q;
    held_d = held_q;
    if (pend_q) begin
      held_d = pins;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      held_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (pend_q) held_q <= held_d;
    end
  end

  assign held = held_q;

  // R1: once captured, the snapshot never moves until hard reset
  a_r1_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(held_q));

  // R1: capture happens exactly once per hard reset
  a_r1_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> !pend_q);

endmodule

// File: rtl/strap_override.sv
module strap_override
  import strap_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_en,
  input  logic            wr_blk,
  input  logic [2:0]      wr_sel,
  input  logic [WR_W-1:0] wr_val,
  input  raw_t            base,
  output raw_t            eff
);

  logic [NUM_FLD-1:0] vld_q, vld_d;
  raw_t               ovr_q, ovr_d;
  logic               wr_go;

  assign wr_go = wr_en && !wr_blk;

  always_comb begin
    vld_d = vld_q;
    ovr_d = ovr_q;
    if (clr) begin
      vld_d = '0;
    end else if (wr_go) begin
      case (wr_sel)
        FLD_ADDR: begin
          vld_d[FLD_ADDR] = 1'b1;
          ovr_d.addr      = wr_val[ADDR_W-1:0];
        end
        FLD_VIO: begin
          vld_d[FLD_VIO] = 1'b1;
          ovr_d.vio      = wr_val[1:0];
        end
        FLD_SUPPLY: begin
          vld_d[FLD_SUPPLY] = 1'b1;
          ovr_d.supply      = wr_val[0];
        end
        FLD_MII: begin
          vld_d[FLD_MII] = 1'b1;
          ovr_d.mii      = wr_val[0];
        end
        FLD_MIRROR: begin
          vld_d[FLD_MIRROR] = 1'b1;
          ovr_d.mirror      = wr_val[0];
        end
        FLD_LINK: begin
          vld_d[FLD_LINK] = 1'b1;
          ovr_d.an_dis    = wr_val[2];
          ovr_d.lsel      = wr_val[1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ovr_q <= '0;
    end else begin
      if (clr || wr_go) begin
        vld_q <= vld_d;
        ovr_q <= ovr_d;
      end
    end
  end

  always_comb begin
    eff = base;
    if (vld_q[FLD_ADDR])   eff.addr   = ovr_q.addr;
    if (vld_q[FLD_VIO])    eff.vio    = ovr_q.vio;
    if (vld_q[FLD_SUPPLY]) eff.supply = ovr_q.supply;
    if (vld_q[FLD_MII])    eff.mii    = ovr_q.mii;
    if (vld_q[FLD_MIRROR]) eff.mirror = ovr_q.mirror;
    if (vld_q[FLD_LINK]) begin
      eff.an_dis = ovr_q.an_dis;
      eff.lsel   = ovr_q.lsel;
    end
  end

  // R8: a blocked write leaves every override untouched
  a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blk && !clr) |=> ($stable(vld_q) && $stable(ovr_q)));

  // R9: any reset drops all overrides
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_cfg_pkg::*;
(
  input  raw_t              raw,
  output logic [ADDR_W-1:0] addr,
  output vio_e              vio,
  output logic              supply,
  output logic              mii,
  output logic              mirror,
  output link_e             link,
  output logic              rsv
);

  logic vio_rsv, link_rsv;

  always_comb begin
    addr   = raw.addr;
    supply = raw.supply;
    mii    = raw.mii;
    mirror = raw.mirror;

    vio_rsv = 1'b0;
    case (raw.vio)
      2'b00:   vio = VIO_3V3;
      2'b10:   vio = VIO_2V5;
      2'b11:   vio = VIO_1V8;
      default: begin
        vio     = VIO_3V3;
        vio_rsv = 1'b1;
      end
    endcase

    link_rsv = 1'b0;
    if (!raw.an_dis) begin
      case (raw.lsel)
        2'b00:   link = LM_AN_ALL;
        2'b01:   link = LM_AN_GIG;
        2'b10:   link = LM_AN_FAST;
        default: begin
          link     = LM_AN_ALL;
          link_rsv = 1'b1;
        end
      endcase
    end else begin
      case (raw.lsel)
        2'b00:   link = LM_F1000_M;
        2'b01:   link = LM_F1000_S;
        2'b10:   link = LM_F100_STR;
        default: link = LM_F100_X;
      endcase
    end

    rsv = vio_rsv | link_rsv;
  end

endmodule

// File: rtl/strap_recover.sv
module strap_recover #(
  parameter int PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic en,
  output logic irq,
  output logic lrst
);

  localparam int CW = $clog2(PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE - 1);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (evt && en) begin
      act_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      irq_q <= evt;
    end
  end

  assign irq  = irq_q;
  assign lrst = act_q;

  // R11: every event is reported in the next cycle
  a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq);

  // R12: an enabled event while idle starts the pulse
  a_r12_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && en && !act_q) |=> act_q);

  // R12: the counter never runs past the pulse width
  a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q <= LAST));

  // R12: the pulse ends only after its full width
  a_r12_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REC_PULSE   = 4
) (
  input  logic              clk,
  input  logic              por_rst_n,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] strap_addr_lvl,
  input  logic [1:0]        strap_vio,
  input  logic              strap_supply,
  input  logic              strap_mii,
  input  logic              strap_recover,
  input  logic              strap_mirror,
  input  logic              strap_wr_dis,
  input  logic              strap_an_dis,
  input  logic [1:0]        strap_lsel,
  input  logic              fault_evt,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WR_W-1:0]   wr_val,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [1:0]        io_volt,
  output logic              triple_supply,
  output logic              mii_mode,
  output logic              mirror_en,
  output logic              wr_blocked,
  output logic [2:0]        link_mode,
  output logic              rsv_seen,
  output logic              fault_irq,
  output logic              logic_rst
);

  logic   rst_int_n;
  strap_t pins, held;
  raw_t   eff;
  vio_e   vio_dec;
  link_e  link_dec;
  logic   dec_rsv;
  logic   rsv_q, rsv_d;
  logic   ovr_clr;

  strap_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (por_rst_n),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    pins.cfg.addr   = strap_addr_lvl;
    pins.cfg.vio    = strap_vio;
    pins.cfg.supply = strap_supply;
    pins.cfg.mii    = strap_mii;
    pins.cfg.mirror = strap_mirror;
    pins.cfg.an_dis = strap_an_dis;
    pins.cfg.lsel   = strap_lsel;
    pins.wr_dis     = strap_wr_dis;
    pins.recover    = strap_recover;
  end

  strap_latch u_latch (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pins  (pins),
    .held  (held)
  );

  strap_recover #(.PULSE(REC_PULSE)) u_rec (
    .clk   (clk),
    .rst_n (rst_int_n),
    .evt   (fault_evt),
    .en    (held.recover),
    .irq   (fault_irq),
    .lrst  (logic_rst)
  );

  assign ovr_clr = sw_rst | logic_rst;

  strap_override u_ovr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (ovr_clr),
    .wr_en  (wr_en),
    .wr_blk (held.wr_dis | logic_rst),
    .wr_sel (wr_sel),
    .wr_val (wr_val),
    .base   (held.cfg),
    .eff    (eff)
  );

  strap_decode u_dec (
    .raw    (eff),
    .addr   (phy_addr),
    .vio    (vio_dec),
    .supply (triple_supply),
    .mii    (mii_mode),
    .mirror (mirror_en),
    .link   (link_dec),
    .rsv    (dec_rsv)
  );

  assign io_volt    = vio_dec;
  assign link_mode  = link_dec;
  assign wr_blocked = held.wr_dis;

  always_comb begin
    rsv_d = rsv_q | dec_rsv;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   rsv_q <= 1'b0;
    else if (dec_rsv) rsv_q <= rsv_d;
  end

  assign rsv_seen = rsv_q;

  // R10: the reserved flag is sticky until hard reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsv_q |=> rsv_q);

  // R10: a selected reserved code always raises the flag
  a_r10_sets: assert property (@(posedge clk) disable iff (!rst_int_n)
    dec_rsv |=> rsv_q);

  // R4: decoded voltage never takes the unused code
  a_r4_vio_legal: assert property (@(posedge clk) disable iff (!rst_int_n)
    io_volt != 2'd3);

endmodule

// File: tb/strap_cfg_top_bench.sv
module strap_cfg_top_bench;

  logic       clk = 1'b0;
  logic       por_rst_n, sw_rst;
  logic [3:0] strap_addr_lvl;
  logic [1:0] strap_vio, strap_lsel;
  logic       strap_supply, strap_mii, strap_recover, strap_mirror;
  logic       strap_wr_dis, strap_an_dis;
  logic       fault_evt, wr_en;
  logic [2:0] wr_sel;
  logic [3:0] wr_val;
  logic [3:0] phy_addr;
  logic [1:0] io_volt;
  logic       triple_supply, mii_mode, mirror_en, wr_blocked;
  logic [2:0] link_mode;
  logic       rsv_seen, fault_irq, logic_rst;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #2 clk = ~clk;

  strap_cfg_top u_strap_cfg_top (
    .clk(clk), .por_rst_n(por_rst_n), .sw_rst(sw_rst),
    .strap_addr_lvl(strap_addr_lvl), .strap_vio(strap_vio),
    .strap_supply(strap_supply), .strap_mii(strap_mii),
    .strap_recover(strap_recover), .strap_mirror(strap_mirror),
    .strap_wr_dis(strap_wr_dis), .strap_an_dis(strap_an_dis),
    .strap_lsel(strap_lsel), .fault_evt(fault_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .phy_addr(phy_addr), .io_volt(io_volt),
    .triple_supply(triple_supply), .mii_mode(mii_mode),
    .mirror_en(mirror_en), .wr_blocked(wr_blocked),
    .link_mode(link_mode), .rsv_seen(rsv_seen),
    .fault_irq(fault_irq), .logic_rst(logic_rst)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_pins(logic [3:0] a, logic [1:0] v, logic sup, logic mii,
                          logic rec, logic mir, logic wd, logic an, logic [1:0] ls);
    strap_addr_lvl = a;  strap_vio = v;     strap_supply = sup;
    strap_mii      = mii; strap_recover = rec; strap_mirror = mir;
    strap_wr_dis   = wd; strap_an_dis = an; strap_lsel = ls;
  endtask

  // hard reset, return on the falling edge after the fourth rising edge
  task automatic hard_reset();
    @(negedge clk);
    por_rst_n = 1'b0; sw_rst = 1'b0; wr_en = 1'b0; fault_evt = 1'b0;
    wr_sel = '0; wr_val = '0;
    repeat (2) @(negedge clk);
    por_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // invert every strap pin, then let one edge pass
  task automatic scramble();
    strap_addr_lvl = ~strap_addr_lvl; strap_vio = ~strap_vio;
    strap_supply = ~strap_supply; strap_mii = ~strap_mii;
    strap_mirror = ~strap_mirror; strap_an_dis = ~strap_an_dis;
    strap_lsel = ~strap_lsel; strap_wr_dis = ~strap_wr_dis;
    strap_recover = ~strap_recover;
    @(negedge clk);
  endtask

  task automatic mwrite(logic [2:0] s, logic [3:0] v);
    wr_en = 1'b1; wr_sel = s; wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    set_pins(4'hF, 2'b11, 1, 1, 1, 1, 1, 1, 2'b11);
    @(negedge clk);
    por_rst_n = 1'b0; sw_rst = 1'b0; wr_en = 1'b0; fault_evt = 1'b0;
    wr_sel = '0; wr_val = '0;
    @(negedge clk);
    chk("R7", "reset addr", phy_addr, 0);
    chk("R7", "reset volt", io_volt, 0);
    chk("R7", "reset link", link_mode, 0);
    chk("R7", "reset flags", {triple_supply, mii_mode, mirror_en, wr_blocked,
                              rsv_seen, fault_irq, logic_rst}, 0);
  endtask

  task automatic t_addr();
    set_pins(4'b0110, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    scramble();
    chk("R1", "addr after scramble", phy_addr, 4'h6);
    set_pins(4'b0011, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    chk("R3", "addr lo level 3", phy_addr, 4'h3);
    set_pins(4'b1100, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    scramble();
    chk("R3", "addr hi level 3", phy_addr, 4'hC);
  endtask

  task automatic t_vio();
    logic [1:0] codes [3] = '{2'b00, 2'b10, 2'b11};
    for (int i = 0; i < 3; i++) begin
      set_pins(4'h0, codes[i], 0, 0, 0, 0, 0, 0, 2'b00);
      hard_reset();
      scramble();
      chk("R4", "volt decode", io_volt, i);
      chk("R10", "no reserved flag", rsv_seen, 0);
    end
    set_pins(4'h0, 2'b01, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    chk("R4", "reserved volt fallback", io_volt, 0);
    chk("R10", "reserved volt flag", rsv_seen, 1);
  endtask

  task automatic t_link();
    for (int s = 0; s < 3; s++) begin
      set_pins(4'h0, 2'b00, 0, 0, 0, 0, 0, 0, 2'(s));
      hard_reset();
      scramble();
      chk("R5", "advertise mode", link_mode, s);
    end
    set_pins(4'h0, 2'b00, 0, 0, 0, 0, 0, 0, 2'b11);
    hard_reset();
    chk("R5", "reserved advertise fallback", link_mode, 0);
    chk("R10", "reserved link flag", rsv_seen, 1);
    for (int s = 0; s < 4; s++) begin
      set_pins(4'h0, 2'b00, 0, 0, 0, 0, 0, 1, 2'(s));
      hard_reset();
      scramble();
      chk("R6", "forced mode", link_mode, 3 + s);
      chk("R6", "forced no flag", rsv_seen, 0);
    end
  endtask

  task automatic t_misc();
    set_pins(4'h0, 2'b00, 1, 1, 0, 1, 0, 0, 2'b00);
    hard_reset();
    scramble();
    chk("R7", "supply/mii/mirror", {triple_supply, mii_mode, mirror_en}, 3'b111);
    set_pins(4'h0, 2'b00, 0, 1, 0, 0, 0, 0, 2'b00);
    hard_reset();
    chk("R7", "mii only", {triple_supply, mii_mode, mirror_en}, 3'b010);
  endtask

  task automatic t_sw();
    set_pins(4'h5, 2'b10, 0, 0, 0, 0, 0, 0, 2'b01);
    hard_reset();
    mwrite(3'd0, 4'h9);
    chk("R9", "addr override", phy_addr, 4'h9);
    mwrite(3'd5, 4'b0110);
    chk("R9", "link override", link_mode, 5);
    mwrite(3'd4, 4'h1);
    chk("R9", "mirror override", mirror_en, 1);
    scramble();
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk("R2", "addr restored", phy_addr, 4'h5);
    chk("R2", "link restored", link_mode, 1);
    chk("R2", "volt restored", io_volt, 1);
    chk("R2", "mirror restored", mirror_en, 0);
  endtask

  task automatic t_block();
    set_pins(4'h2, 2'b00, 0, 0, 0, 0, 1, 0, 2'b00);
    hard_reset();
    chk("R8", "wr_blocked", wr_blocked, 1);
    mwrite(3'd0, 4'hA);
    mwrite(3'd3, 4'h1);
    chk("R8", "addr unchanged", phy_addr, 4'h2);
    chk("R8", "mii unchanged", mii_mode, 0);
  endtask

  task automatic t_rsv_write();
    set_pins(4'h0, 2'b11, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    chk("R10", "flag clear", rsv_seen, 0);
    mwrite(3'd1, 4'b0001);
    chk("R10", "written reserved fallback", io_volt, 0);
    @(negedge clk);
    chk("R10", "written reserved flag", rsv_seen, 1);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    chk("R10", "flag survives sw reset", rsv_seen, 1);
    chk("R2", "volt back to strap", io_volt, 2);
  endtask

  task automatic t_fault();
    int highs;
    set_pins(4'h5, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
    hard_reset();
    fault_evt = 1'b1;
    @(negedge clk);
    fault_evt = 1'b0;
    chk("R11", "irq without recovery", fault_irq, 1);
    chk("R11", "no logic reset", logic_rst, 0);
    @(negedge clk);
    chk("R11", "irq one cycle", fault_irq, 0);

    set_pins(4'h5, 2'b00, 0, 0, 1, 0, 0, 0, 2'b00);
    hard_reset();
    mwrite(3'd0, 4'h9);
    chk("R9", "override before fault", phy_addr, 4'h9);
    fault_evt = 1'b1;
    @(negedge clk);
    fault_evt = 1'b0;
    chk("R11", "irq with recovery", fault_irq, 1);
    chk("R12", "logic reset starts", logic_rst, 1);
    highs = 1;
    for (int i = 0; i < 7; i++) begin
      if (i == 1) begin
        fault_evt = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_val = 4'hC;
      end
      @(negedge clk);
      fault_evt = 1'b0; wr_en = 1'b0;
      if (logic_rst) highs++;
    end
    chk("R12", "pulse width", highs, 4);
    chk("R12", "override cleared, write ignored", phy_addr, 4'h5);
  endtask

  initial begin
    por_rst_n = 1'b0; sw_rst = 1'b0; fault_evt = 1'b0; wr_en = 1'b0;
    wr_sel = '0; wr_val = '0;
    set_pins(4'h0, 2'b00, 0, 0, 0, 0, 0, 0, 2'b00);
    t_reset();
    t_addr();
    t_vio();
    t_link();
    t_misc();
    t_sw();
    t_block();
    t_rsv_write();
    t_fault();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule